// File: doc/BRIEF.md
# Receive Frame Buffer with Overflow Control

This block sits between a MAC's receive byte stream and a DMA engine that drains whole frames. Bytes go into a circular byte store, and each finished frame is logged in a small table that records its length and status. The drain port hands out one byte per valid/ready transfer. The final byte of each frame carries a last marker and the frame status.

Two causes of overflow are tracked apart, and each has its own rule for resuming. A full frame table makes a new frame get refused whole. Reception resumes as soon as the table has room again. A full byte store also makes a new frame get refused whole. Reception then resumes only once draining has freed a minimum block of bytes. A frame that fills the store part way through is cut short and still delivered, marked as truncated. Frames that end in a receive error are flushed if they are too short, with the configured pad count included in the length. Longer errored frames are delivered with an error status.

Sticky status flags feed an interrupt through per-flag enables. A saturating counter records the frames discarded by either overflow cause.

Top module: `rx_frame_buffer`

## Requirements
- R1: The frame table holds at most 24 undrained frames. A frame whose start byte arrives while 24 are held is discarded whole and sets flag bit 1 (frame-count overflow).
- R2: A frame whose start byte arrives while the byte store is refusing data is discarded whole and sets flag bit 0 (data overflow). The byte store holds 2048 bytes.
- R3: After the store fills, new frames are refused until at least 32 bytes of space are free.
- R4: After a frame-count overflow, a new frame is accepted once one frame has been fully drained.
- R5: `drop_cnt` rises by one for each frame discarded by either overflow cause. It does not rise for truncated or flushed frames, and it holds at 65535.
- R6: When the store fills inside a frame, the bytes already stored are delivered with `out_status` bit 1 (truncated) set. Flag bit 2 is set when that frame's last byte is drained, and not before.
- R7: A frame that ends with `in_err` is flushed when its byte count plus `pad_len` is below 32. Nothing of it appears on the drain port.
- R8: An errored frame whose byte count plus `pad_len` is 32 or more is delivered with `out_status` bit 0 set. Flag bits 3 (frame error) and 4 (receive abort) are set when its last byte is drained. Pad bytes are counted only and are never inserted into the data.
- R9: Flags are sticky and are cleared by a 1 on the matching `flag_clr` bit. `irq` is the OR of `flags & irq_en`.
- R10: The drain port moves one byte on each cycle where `out_valid` and `out_ready` are both high, in arrival order. `out_last` marks the final byte of a frame, and `out_status` is zero on every other byte.
- R11: After reset `out_valid`, `flags`, `drop_cnt` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Receive byte present |
| in_data | input | 8 | Receive byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_err | input | 1 | Receive error, valid with `in_eof` |
| pad_len | input | 6 | Pad byte count added to the runt-length check |
| out_valid | output | 1 | Drain byte available |
| out_ready | input | 1 | Drain side accepts the byte |
| out_data | output | 8 | Drain byte |
| out_last | output | 1 | Final byte of the frame |
| out_status | output | 2 | Frame status on the final byte: bit 0 error, bit 1 truncated |
| flag_clr | input | 5 | Write-1 clear for the flags |
| irq_en | input | 5 | Interrupt enable per flag |
| flags | output | 5 | Sticky flags: 0 data overflow, 1 frame-count overflow, 2 truncated, 3 frame error, 4 receive abort |
| drop_cnt | output | 16 | Saturating count of discarded frames |
| irq | output | 1 | Interrupt request |

## Verification
The bench works the runt boundary from both sides, with and without pad credit. A wrong comparison would deliver a 31-byte errored frame or flush a 32-byte one. It fills the store with a long frame and probes the 32-byte resume threshold one drain step below it and exactly at it. A design that resumed on any free space would accept the frame that must be dropped. It also checks that the truncation flag stays clear until the cut frame is fully drained, and that the drop counter ignores truncation. The frame table is filled to exactly 24 to show that the next frame is refused and that a single drained frame reopens reception. Finally, a long burst of refused frames shows that the counter holds at its maximum instead of wrapping.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;
  localparam int NFLAG    = 5;
  localparam int F_DOVF   = 0;
  localparam int F_COVF   = 1;
  localparam int F_TRUNC  = 2;
  localparam int F_FERR   = 3;
  localparam int F_ABORT  = 4;

  typedef enum logic [1:0] {WS_IDLE, WS_RECV, WS_SKIP} wr_state_t;

  typedef struct packed {
    logic trunc;
    logic err;
  } fstat_t;
endpackage

// File: rtl/rxfb_byte_ram.sv
module rxfb_byte_ram #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxfb_frame_table.sv
module rxfb_frame_table
  import rxfb_pkg::*;
#(
  parameter int ENTRIES = 24,
  parameter int LW      = 12,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int TW = $clog2(ENTRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [LW-1:0] push_len,
  input  fstat_t        push_stat,
  input  logic          pop,
  output logic [LW-1:0] head_len,
  output fstat_t        head_stat,
  output logic [TW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [LW-1:0] len_q  [ENTRIES];
  fstat_t        stat_q [ENTRIES];
  logic [IW-1:0] wr_idx, rd_idx;

  function automatic logic [IW-1:0] idx_next(input logic [IW-1:0] i);
    return (i == IW'(ENTRIES - 1)) ? '0 : i + IW'(1);
  endfunction

  assign full      = (count == TW'(ENTRIES));
  assign empty     = (count == '0);
  assign head_len  = len_q[rd_idx];
  assign head_stat = stat_q[rd_idx];

  always_ff @(posedge clk) begin
    if (push) begin
      len_q[wr_idx]  <= push_len;
      stat_q[wr_idx] <= push_stat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (push) wr_idx <= idx_next(wr_idx);
      if (pop)  rd_idx <= idx_next(rd_idx);
      count <= count + TW'(push) - TW'(pop);
    end
  end

  assert_table_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= TW'(ENTRIES));
  assert_no_push_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/rx_frame_buffer.sv
module rx_frame_buffer
  import rxfb_pkg::*;
#(
  parameter int DEPTH        = 2048,
  parameter int MAX_FRAMES   = 24,
  parameter int MIN_LEN      = 32,
  parameter int RESUME_BYTES = 32,
  parameter int PADW         = 6,
  parameter int CNTW         = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int LW = AW + 1,
  localparam int TW = $clog2(MAX_FRAMES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  input  logic            in_sof,
  input  logic            in_eof,
  input  logic            in_err,
  input  logic [PADW-1:0] pad_len,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [7:0]      out_data,
  output logic            out_last,
  output logic [1:0]      out_status,
  input  logic [NFLAG-1:0] flag_clr,
  input  logic [NFLAG-1:0] irq_en,
  output logic [NFLAG-1:0] flags,
  output logic [CNTW-1:0] drop_cnt,
  output logic            irq
);
  // ---- arithmetic helpers ----
  function automatic logic [PW-1:0] free_space(input logic [PW-1:0] wp, input logic [PW-1:0] rp);
    return PW'(DEPTH) - (wp - rp);
  endfunction

  function automatic logic is_runt(input logic [LW-1:0] len, input logic [PADW-1:0] pad);
    return ((LW+PADW)'(len) + (LW+PADW)'(pad)) < (LW+PADW)'(MIN_LEN);
  endfunction

  // ---- state ----
  wr_state_t       wst;
  logic [PW-1:0]   wptr, rptr, fstart;
  logic [LW-1:0]   wlen, rcnt;
  logic            blk_data;

  // ---- named events ----
  logic [PW-1:0]   free_b;
  logic            sof_evt, cnt_stop, data_stop, start_ok;
  logic            ovf_cnt_evt, ovf_data_evt, in_frame_byte;
  logic            trunc_evt, wr_en, end_evt, flush_evt, push, pop, rd_fire, rd_last;
  logic [LW-1:0]   cur_len, push_len;
  logic [PW-1:0]   frame_base;
  fstat_t          push_stat, head_stat;
  logic [LW-1:0]   head_len;
  logic [TW-1:0]   tbl_count;
  logic            tbl_full, tbl_empty;
  logic [NFLAG-1:0] flag_set;

  assign free_b       = free_space(wptr, rptr);
  assign sof_evt      = in_valid && in_sof;
  assign cnt_stop     = tbl_full;
  assign data_stop    = (free_b == '0) || (blk_data && (free_b < PW'(RESUME_BYTES)));
  assign ovf_cnt_evt  = sof_evt && cnt_stop;
  assign ovf_data_evt = sof_evt && !cnt_stop && data_stop;
  assign start_ok     = sof_evt && !cnt_stop && !data_stop;
  assign in_frame_byte = start_ok || (in_valid && !in_sof && (wst == WS_RECV));
  assign trunc_evt    = in_frame_byte && (free_b == '0);
  assign wr_en        = in_frame_byte && (free_b != '0);
  assign cur_len      = (start_ok ? '0 : wlen) + LW'(1);
  assign frame_base   = start_ok ? wptr : fstart;
  assign end_evt      = wr_en && in_eof;
  assign flush_evt    = end_evt && in_err && is_runt(cur_len, pad_len);
  assign push         = trunc_evt || (end_evt && !flush_evt);
  assign push_len     = trunc_evt ? wlen : cur_len;
  assign push_stat    = '{trunc: trunc_evt, err: !trunc_evt && in_err};

  // ---- storage ----
  rxfb_byte_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wptr[AW-1:0]), .wdata(in_data),
    .raddr(rptr[AW-1:0]), .rdata(out_data)
  );

  rxfb_frame_table #(.ENTRIES(MAX_FRAMES), .LW(LW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .push(push), .push_len(push_len), .push_stat(push_stat),
    .pop(pop), .head_len(head_len), .head_stat(head_stat), .count(tbl_count),
    .full(tbl_full), .empty(tbl_empty)
  );

  // ---- write side ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wst      <= WS_IDLE;
      wptr     <= '0;
      fstart   <= '0;
      wlen     <= '0;
      blk_data <= 1'b0;
    end else begin
      if (sof_evt) begin
        if (start_ok) wst <= in_eof ? WS_IDLE : WS_RECV;
        else          wst <= in_eof ? WS_IDLE : WS_SKIP;
      end else if (in_valid && wst == WS_RECV) begin
        if (trunc_evt)   wst <= in_eof ? WS_IDLE : WS_SKIP;
        else if (in_eof) wst <= WS_IDLE;
      end else if (in_valid && wst == WS_SKIP && in_eof) begin
        wst <= WS_IDLE;
      end

      if (start_ok) fstart <= wptr;
      if (flush_evt)  wptr <= frame_base;
      else if (wr_en) wptr <= wptr + PW'(1);
      if (wr_en) wlen <= cur_len;

      if (ovf_data_evt || trunc_evt)           blk_data <= 1'b1;
      else if (free_b >= PW'(RESUME_BYTES))    blk_data <= 1'b0;
    end
  end

  // ---- drain side ----
  assign out_valid  = !tbl_empty;
  assign rd_last    = (rcnt == head_len - LW'(1));
  assign out_last   = out_valid && rd_last;
  assign out_status = out_last ? {head_stat.trunc, head_stat.err} : 2'b00;
  assign rd_fire    = out_valid && out_ready;
  assign pop        = rd_fire && rd_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr <= '0;
      rcnt <= '0;
    end else if (rd_fire) begin
      rptr <= rptr + PW'(1);
      rcnt <= rd_last ? '0 : rcnt + LW'(1);
    end
  end

  // ---- status ----
  always_comb begin
    flag_set          = '0;
    flag_set[F_DOVF]  = ovf_data_evt;
    flag_set[F_COVF]  = ovf_cnt_evt;
    flag_set[F_TRUNC] = pop && head_stat.trunc;
    flag_set[F_FERR]  = pop && head_stat.err;
    flag_set[F_ABORT] = pop && head_stat.err;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags    <= '0;
      drop_cnt <= '0;
    end else begin
      flags <= (flags & ~flag_clr) | flag_set;
      if ((ovf_data_evt || ovf_cnt_evt) && (drop_cnt != '1))
        drop_cnt <= drop_cnt + CNTW'(1);
    end
  end

  assign irq = |(flags & irq_en);

  // ---- assertions ----
  assert_store_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr - rptr) <= PW'(DEPTH));
  assert_drop_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == $past(drop_cnt) + CNTW'(1)));
  assert_trunc_no_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trunc_evt && !sof_evt) |=> (drop_cnt == $past(drop_cnt)));
  assert_flush_rollback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> (wptr == $past(frame_base)));
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(flags) & ~$past(flag_clr)) & ~flags) == '0));
  assert_resume_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && blk_data) |-> (free_b >= PW'(RESUME_BYTES)));
endmodule

// File: tb/tb_rx_frame_buffer.sv
`timescale 1ns/1ps
module tb_rx_frame_buffer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_err = 0, out_ready = 0;
  logic [7:0] in_data = 0;
  logic [5:0] pad_len = 0;
  logic [4:0] flag_clr = 0, irq_en = 0;
  logic out_valid, out_last, irq;
  logic [7:0] out_data;
  logic [1:0] out_status;
  logic [4:0] flags;
  logic [15:0] drop_cnt;

  int n_checks = 0, n_errors = 0;

  always #10 clk = ~clk;

  rx_frame_buffer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
    .in_eof(in_eof), .in_err(in_err), .pad_len(pad_len), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last), .out_status(out_status),
    .flag_clr(flag_clr), .irq_en(irq_en), .flags(flags), .drop_cnt(drop_cnt), .irq(irq)
  );

  // len[21:10] err[9] pad[8:3] delivered[2] status[1:0]
  localparam logic [21:0] VEC [8] = '{
    {12'd40, 1'b0, 6'd0,  1'b1, 2'b00},
    {12'd1,  1'b0, 6'd0,  1'b1, 2'b00},
    {12'd20, 1'b1, 6'd0,  1'b0, 2'b00},
    {12'd31, 1'b1, 6'd0,  1'b0, 2'b00},
    {12'd32, 1'b1, 6'd0,  1'b1, 2'b01},
    {12'd20, 1'b1, 6'd12, 1'b1, 2'b01},
    {12'd20, 1'b1, 6'd11, 1'b0, 2'b00},
    {12'd64, 1'b0, 6'd5,  1'b1, 2'b00}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_frame(input int len, input logic err, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_err = err && (i == len - 1); in_data = 8'(seed + i);
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; in_err = 0;
  endtask

  task automatic drain_n(input int n);
    int got = 0;
    out_ready = 1;
    while (got < n) begin
      if (out_valid) got++;
      @(negedge clk);
    end
    out_ready = 0;
  endtask

  task automatic drain_frame(input int seed, input int exp_len, input logic [1:0] exp_st, input string tag);
    int got = 0, bad = 0, guard = 0;
    logic done = 0;
    logic [1:0] st = 0;
    out_ready = 1;
    while (!done && guard < 5000) begin
      guard++;
      if (out_valid) begin
        if (out_data != 8'(seed + got)) bad++;
        if (!out_last && out_status != 2'b00) bad++;
        got++;
        if (out_last) begin done = 1; st = out_status; end
      end
      @(negedge clk);
    end
    out_ready = 0;
    chk(bad == 0, {tag, " data/status order R10"}, bad, 0);
    chk(got == exp_len, {tag, " length R10"}, got, exp_len);
    chk(st == exp_st, {tag, " final status"}, st, exp_st);
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 5'h1f;
    @(negedge clk); flag_clr = 5'h00;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_errors++; n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(out_valid == 0, "R11 out_valid", out_valid, 0);
    chk(flags == 0, "R11 flags", flags, 0);
    chk(drop_cnt == 0, "R11 drop_cnt", drop_cnt, 0);
    chk(irq == 0, "R11 irq", irq, 0);

    // vector table: R7, R8, R10
    foreach (VEC[k]) begin
      logic [21:0] v;
      v = VEC[k];
      pad_len = v[8:3];
      send_frame(int'(v[21:10]), v[9], k * 16);
      if (v[2]) begin
        chk(out_valid == 1, "R8 frame present", out_valid, 1);
        drain_frame(k * 16, int'(v[21:10]), v[1:0], "R8 vector");
        if (v[9]) begin
          chk(flags[3] && flags[4], "R8 error and abort flags", flags, 5'b11000);
          clear_flags();
        end
      end else begin
        chk(out_valid == 0, "R7 runt flushed", out_valid, 0);
        chk(flags == 0, "R7 no flag on flush", flags, 0);
      end
    end
    pad_len = 0;
    chk(drop_cnt == 0, "R5 no drops for flush", drop_cnt, 0);

    // data overflow and truncation: R2, R3, R5, R6
    send_frame(2100, 0, 7);
    chk(out_valid == 1, "R6 truncated frame kept", out_valid, 1);
    chk(drop_cnt == 0, "R5 truncation not counted", drop_cnt, 0);
    send_frame(10, 0, 90);
    chk(flags[0] == 1, "R2 data overflow flag", flags[0], 1);
    chk(drop_cnt == 1, "R2 data overflow drop", drop_cnt, 1);
    drain_n(20);
    send_frame(10, 0, 90);
    chk(drop_cnt == 2, "R3 refused below 32 free", drop_cnt, 2);
    chk(flags[2] == 0, "R6 trunc flag waits for drain", flags[2], 0);
    drain_n(12);
    send_frame(10, 0, 100);
    chk(drop_cnt == 2, "R3 accepted at 32 free", drop_cnt, 2);
    drain_frame(7 + 32, 2016, 2'b10, "R6 truncated rest");
    chk(flags[2] == 1, "R6 trunc flag after drain", flags[2], 1);
    drain_frame(100, 10, 2'b00, "R3 resumed frame");
    clear_flags();
    chk(flags == 0, "R9 write-1 clear", flags, 0);

    // frame-count overflow: R1, R4, R9
    for (int f = 0; f < 24; f++) send_frame(4, 0, f * 4);
    chk(flags[1] == 0, "R1 24 frames fit", flags[1], 0);
    send_frame(4, 0, 150);
    chk(flags[1] == 1, "R1 count overflow flag", flags[1], 1);
    chk(flags[0] == 0, "R1 not a data overflow", flags[0], 0);
    chk(drop_cnt == 3, "R1 drop counted", drop_cnt, 3);
    @(negedge clk); irq_en = 5'b00010; #1;
    chk(irq == 1, "R9 irq enabled flag", irq, 1);
    irq_en = 5'b00001; #1;
    chk(irq == 0, "R9 irq masked", irq, 0);
    irq_en = 0;
    drain_frame(0, 4, 2'b00, "R4 drain one");
    send_frame(4, 0, 200);
    chk(drop_cnt == 3, "R4 accepted after one drained", drop_cnt, 3);
    chk(flags[1] == 1, "R9 flag sticky", flags[1], 1);

    // saturation: R5
    @(negedge clk);
    in_valid = 1; in_sof = 1; in_eof = 1; in_data = 8'h55;
    repeat (65540) @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
    @(negedge clk);
    chk(drop_cnt == 16'hffff, "R5 counter saturates", drop_cnt, 65535);

    for (int f = 1; f < 24; f++) drain_frame(f * 4, 4, 2'b00, "R1 queued frame");
    drain_frame(200, 4, 2'b00, "R4 late frame");
    chk(out_valid == 0, "R10 table empty", out_valid, 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule